// File: doc/BRIEF.md
# PHY Register Access Controller

This block is one 32-bit control word through which software reaches the registers of a separate PHY core. Software writes a word that names a PHY register, carries a byte to write, and raises either a read-request bit or a write-request bit. The block turns that word into a single request on a valid/ready interface toward the PHY. The request bit clears itself when the PHY accepts the request.

Independently, the PHY can return a register transfer on a one-cycle strobe. The block captures the returned register number and value in their own fields and raises a completion flag. The returned register number is kept apart from the number software asked for, because the PHY may also report a register on its own initiative.

Software reads the whole word back at any time through a combinational read port. The PHY address and data widths are parameters, up to four and eight bits. A parameter can add one register stage on the response path.

Top module: `phy_regacc`

## Requirements
- R1: After reset the read word is 0x00000000 and `req_valid` is low.
- R2: A software write with bit 15 set and bit 14 clear raises `req_valid` in the next cycle with `req_is_write`=0 and `req_addr` equal to bits 11:8 of the written word; bit 15 reads back as 1.
- R3: A software write with bit 14 set and bit 15 clear raises `req_valid` with `req_is_write`=1, `req_addr` = bits 11:8 and `req_data` = bits 7:0; bit 14 reads back as 1.
- R4: While `req_ready` is low, `req_valid`, `req_is_write`, `req_addr` and `req_data` hold steady. In the cycle after `req_valid` and `req_ready` are both high, `req_valid` is low and bits 15 and 14 read 0.
- R5: A write with bits 15 and 14 both set issues only a read: `req_is_write`=0, bit 15 reads 1 and bit 14 reads 0.
- R6: Bit 31 (done) is cleared by a software write with bit 15 or bit 14 set. A software write with neither bit set leaves it unchanged.
- R7: A cycle with `rsp_valid` high loads `rsp_addr` into bits 27:24 and `rsp_data` into bits 23:16 and sets bit 31 one cycle later (at the default latency of 0). This happens whether or not a read is pending.
- R8: When a request-raising write and `rsp_valid` fall in the same cycle, the response wins: bit 31 ends at 1, and the new request is still issued.
- R9: Bits 30:28 and 13:12 always read 0. Software writes to bits 31:16 are ignored.
- R10: At most one of bits 15 and 14 is ever set. After a handshake no further request appears until software writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe for the control word |
| sw_wdata | input | 32 | Word written by software |
| sw_rdata | output | 32 | Current control word as seen by software |
| req_valid | output | 1 | Request toward the PHY is pending |
| req_ready | input | 1 | PHY accepts the pending request |
| req_is_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | ADDR_W | PHY register number of the request |
| req_data | output | DATA_W | Byte to write to the PHY register |
| rsp_valid | input | 1 | PHY returns a register transfer this cycle |
| rsp_addr | input | ADDR_W | Register number of the returned transfer |
| rsp_data | input | DATA_W | Value of the returned register |

## Verification
The hardest case to reach is a response that arrives in the same cycle as a software write that raises a request. In that cycle the clear and the set of the done flag compete. The bench drives `rsp_valid` and `sw_wr_en` on the same falling edge to produce it. It also holds `req_ready` low for several cycles before a single-cycle handshake, which shows both that the request holds steady and that it clears itself. A response with no read pending is produced directly after a write request completes.

// File: rtl/phy_regacc_pkg.sv
package phy_regacc_pkg;
   localparam int REG_W       = 32;
   localparam int ADDR_W_MAX  = 4;
   localparam int DATA_W_MAX  = 8;
   // field positions inside the software word
   localparam int P_DONE      = 31;
   localparam int P_RXA_LSB   = 24;
   localparam int P_RXD_LSB   = 16;
   localparam int P_RD        = 15;
   localparam int P_WR        = 14;
   localparam int P_ADDR_LSB  = 8;
   localparam int P_DATA_LSB  = 0;

   typedef enum logic [1:0] {
      REQ_IDLE  = 2'b00,
      REQ_WRITE = 2'b01,
      REQ_READ  = 2'b10
   } req_kind_e;
endpackage

// File: rtl/phy_regacc_cmd.sv
module phy_regacc_cmd
   import phy_regacc_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              want_rd,
   input  logic              want_wr,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic              req_ready,
   output logic              req_valid,
   output logic              req_is_write,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              rd_pend,
   output logic              wr_pend
);
   req_kind_e         kind_q;
   req_kind_e         kind_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   // read wins when both bits are written
   always_comb begin
      kind_d = kind_q;
      if (req_valid && req_ready) kind_d = REQ_IDLE;
      if (load) begin
         if (want_rd)      kind_d = REQ_READ;
         else if (want_wr) kind_d = REQ_WRITE;
         else              kind_d = REQ_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= REQ_IDLE;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         kind_q <= kind_d;
         if (load) begin
            addr_q <= load_addr;
            data_q <= load_data;
         end
      end
   end

   assign rd_pend      = (kind_q == REQ_READ);
   assign wr_pend      = (kind_q == REQ_WRITE);
   assign req_valid    = rd_pend | wr_pend;
   assign req_is_write = wr_pend;
   assign req_addr     = addr_q;
   assign req_data     = data_q;
endmodule

// File: rtl/phy_regacc_rsp.sv
module phy_regacc_rsp #(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int RSP_LAT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   input  logic [ADDR_W-1:0] rsp_addr,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              clr_done,
   output logic              done,
   output logic [ADDR_W-1:0] rx_addr,
   output logic [DATA_W-1:0] rx_data
);
   logic              in_v;
   logic [ADDR_W-1:0] in_a;
   logic [DATA_W-1:0] in_d;

   generate
      if (RSP_LAT == 0) begin : g_direct
         assign in_v = rsp_valid;
         assign in_a = rsp_addr;
         assign in_d = rsp_data;
      end else begin : g_staged
         logic              st_v;
         logic [ADDR_W-1:0] st_a;
         logic [DATA_W-1:0] st_d;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_v <= 1'b0;
               st_a <= '0;
               st_d <= '0;
            end else begin
               st_v <= rsp_valid;
               st_a <= rsp_addr;
               st_d <= rsp_data;
            end
         end
         assign in_v = st_v;
         assign in_a = st_a;
         assign in_d = st_d;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done    <= 1'b0;
         rx_addr <= '0;
         rx_data <= '0;
      end else begin
         if (in_v) begin
            done    <= 1'b1;
            rx_addr <= in_a;
            rx_data <= in_d;
         end else if (clr_done) begin
            done    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/phy_regacc.sv
module phy_regacc
   import phy_regacc_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int RSP_LAT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic [REG_W-1:0]  sw_wdata,
   output logic [REG_W-1:0]  sw_rdata,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_is_write,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   input  logic              rsp_valid,
   input  logic [ADDR_W-1:0] rsp_addr,
   input  logic [DATA_W-1:0] rsp_data
);
   generate
      if (ADDR_W < 1 || ADDR_W > ADDR_W_MAX) begin : g_bad_addr_w
         initial $fatal(1, "phy_regacc: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > DATA_W_MAX) begin : g_bad_data_w
         initial $fatal(1, "phy_regacc: DATA_W out of range");
      end
      if (RSP_LAT < 0 || RSP_LAT > 1) begin : g_bad_lat
         initial $fatal(1, "phy_regacc: RSP_LAT must be 0 or 1");
      end
   endgenerate

   logic              rd_pend, wr_pend, done;
   logic [ADDR_W-1:0] rx_addr;
   logic [DATA_W-1:0] rx_data;
   logic              raise;
   logic              unused_wbits;

   assign raise        = sw_wr_en & (sw_wdata[P_RD] | sw_wdata[P_WR]);
   assign unused_wbits = ^sw_wdata;

   phy_regacc_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (sw_wr_en),
      .want_rd      (sw_wdata[P_RD]),
      .want_wr      (sw_wdata[P_WR]),
      .load_addr    (sw_wdata[P_ADDR_LSB +: ADDR_W]),
      .load_data    (sw_wdata[P_DATA_LSB +: DATA_W]),
      .req_ready    (req_ready),
      .req_valid    (req_valid),
      .req_is_write (req_is_write),
      .req_addr     (req_addr),
      .req_data     (req_data),
      .rd_pend      (rd_pend),
      .wr_pend      (wr_pend)
   );

   phy_regacc_rsp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSP_LAT(RSP_LAT)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsp_valid (rsp_valid),
      .rsp_addr  (rsp_addr),
      .rsp_data  (rsp_data),
      .clr_done  (raise),
      .done      (done),
      .rx_addr   (rx_addr),
      .rx_data   (rx_data)
   );

   always_comb begin
      sw_rdata                         = '0;
      sw_rdata[P_DONE]                 = done;
      sw_rdata[P_RXA_LSB +: ADDR_W]    = rx_addr;
      sw_rdata[P_RXD_LSB +: DATA_W]    = rx_data;
      sw_rdata[P_RD]                   = rd_pend;
      sw_rdata[P_WR]                   = wr_pend;
      sw_rdata[P_ADDR_LSB +: ADDR_W]   = req_addr;
      sw_rdata[P_DATA_LSB +: DATA_W]   = req_data;
   end
endmodule

// File: rtl/phy_regacc_chk.sv
module phy_regacc_chk #(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int RSP_LAT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_wr_en,
   input logic [31:0]       sw_wdata,
   input logic [31:0]       sw_rdata,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_is_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [DATA_W-1:0] rsp_data
);
   logic lat0;
   assign lat0 = (RSP_LAT == 0);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready && !sw_wr_en |=>
         req_valid && $stable(req_is_write) && $stable(req_addr) && $stable(req_data));

   p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !sw_wr_en |=> !req_valid);

   p_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en && sw_wdata[15] |=> req_valid && !req_is_write);

   p_write_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en && sw_wdata[14] && !sw_wdata[15] |=>
         req_valid && req_is_write && req_data == $past(sw_wdata[DATA_W-1:0]));

   p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lat0 && sw_wr_en && (sw_wdata[15] || sw_wdata[14]) && !rsp_valid |=> !sw_rdata[31]);

   p_rsp_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lat0 && rsp_valid |=> sw_rdata[31] && sw_rdata[24 +: ADDR_W] == $past(rsp_addr)
         && sw_rdata[16 +: DATA_W] == $past(rsp_data));

   p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rdata[30:28] == 3'b000 && sw_rdata[13:12] == 2'b00);

   p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_rdata[15:14]) && (req_valid == (sw_rdata[15] | sw_rdata[14])));
endmodule

bind phy_regacc phy_regacc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSP_LAT(RSP_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
   .sw_rdata(sw_rdata), .req_valid(req_valid), .req_ready(req_ready),
   .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
);

// File: tb/phy_regacc_tb_top.sv
module phy_regacc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] sw_rdata;
   logic        req_valid, req_is_write;
   logic        req_ready = 1'b0;
   logic [3:0]  req_addr;
   logic [7:0]  req_data;
   logic        rsp_valid = 1'b0;
   logic [3:0]  rsp_addr = '0;
   logic [7:0]  rsp_data = '0;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   phy_regacc dut_i (
      .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
      .sw_rdata(sw_rdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sw_write(input logic [31:0] w);
      @(negedge clk);
      sw_wr_en = 1'b1;
      sw_wdata = w;
      @(negedge clk);
      sw_wr_en = 1'b0;
      sw_wdata = '0;
   endtask

   task automatic rsp_send(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_addr = a; rsp_data = d;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic handshake();
      @(negedge clk);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 word", sw_rdata, 32'h0);
      chk("R1 valid", {31'b0, req_valid}, 32'h0);
   endtask

   task automatic t_read_hold();
      sw_write(32'hFFFF_8300);
      chk("R2 valid", {31'b0, req_valid}, 32'h1);
      chk("R2 kind", {31'b0, req_is_write}, 32'h0);
      chk("R2 addr", {28'b0, req_addr}, 32'h3);
      chk("R9 upper ignored", sw_rdata, 32'h0000_8300);
      repeat (3) @(negedge clk);
      chk("R4 held", {req_valid, req_is_write, req_addr, req_data, sw_rdata[15:14]},
          {1'b1, 1'b0, 4'h3, 8'h00, 2'b10});
      handshake();
      chk("R4 cleared", {req_valid, sw_rdata[15:14]}, 3'b000);
      repeat (2) @(negedge clk);
      chk("R10 no repeat", {31'b0, req_valid}, 32'h0);
   endtask

   task automatic t_rsp_read();
      rsp_send(4'h3, 8'hE1);
      chk("R7 capture", sw_rdata, 32'h83E1_0300);
   endtask

   task automatic t_rsvd();
      sw_write(32'hFFFF_3B77);
      chk("R9 reserved and R6 keep", sw_rdata, 32'h83E1_0B77);
      chk("R9 no req", {31'b0, req_valid}, 32'h0);
   endtask

   task automatic t_write();
      sw_write(32'h0000_4A5C);
      chk("R3 valid/kind", {30'b0, req_valid, req_is_write}, 32'h3);
      chk("R3 addr/data", {20'b0, req_addr, req_data}, 32'h0000_0A5C);
      chk("R6 done cleared", sw_rdata, 32'h03E1_4A5C);
      handshake();
      chk("R4 write cleared", sw_rdata, 32'h03E1_0A5C);
   endtask

   task automatic t_unsolicited();
      rsp_send(4'h7, 8'h42);
      chk("R7 unsolicited", sw_rdata, 32'h8742_0A5C);
   endtask

   task automatic t_both();
      sw_write(32'h0000_C612);
      chk("R5 read only", {30'b0, req_valid, req_is_write}, 32'h2);
      chk("R5 readback", sw_rdata[15:0], 32'h0000_8612);
      handshake();
   endtask

   task automatic t_collide();
      @(negedge clk);
      sw_wr_en = 1'b1; sw_wdata = 32'h0000_8500;
      rsp_valid = 1'b1; rsp_addr = 4'h2; rsp_data = 8'h99;
      @(negedge clk);
      sw_wr_en = 1'b0; sw_wdata = '0; rsp_valid = 1'b0;
      chk("R8 response wins", sw_rdata, 32'h8299_8500);
      chk("R8 request issued", {31'b0, req_valid}, 32'h1);
      handshake();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_hold();
      t_rsp_read();
      t_rsvd();
      t_write();
      t_unsolicited();
      t_both();
      t_collide();
      repeat (2) @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule